// File: doc/BRIEF.md
# Bus-Attached Accumulator Unit

This unit sums a short chain of operands taken from a shared value bus and later places the result back on that bus. The bus is formed by ORing the outputs of every attached unit, so this unit drives zeros in every cycle in which it is not the source. There is no instruction decoder. Four control lines arrive each cycle straight from a central sequencer: reset, load, negate and output-enable.

To start a new sum, the sequencer raises load and reset together, which overwrites the register with the bus operand. Each later load without reset adds the bus operand to the register. With negate raised, the operand is subtracted instead. A cycle with output-enable copies the current sum into an output stage, and the bus carries that copy during the next cycle only. An attribute bit travels with the data and reports whether signed overflow happened at any step of the chain.

Top module: `accum_unit`

## Requirements
- R1: After reset, the bus data output and the overflow attribute are zero, and a readout taken before any load returns zero.
- R2: Load together with reset replaces the sum with the bus value. With negate also raised, the sum becomes the two's-complement negation of the bus value.
- R3: Load without reset adds the bus value to the current sum.
- R4: Load with negate and without reset subtracts the bus value from the current sum.
- R5: A cycle without load leaves the sum and the overflow state unchanged, whatever the negate and bus inputs are.
- R6: Output-enable in cycle t puts the sum held in cycle t on the bus in cycle t+1, for that one cycle only. Back-to-back enables drive in back-to-back cycles.
- R7: In every cycle that does not directly follow an output-enable, both the bus data output and the overflow attribute are zero.
- R8: The sum wraps modulo 2^W.
- R9: The overflow attribute is 1 when signed overflow occurred at any load since the last reset-load. A reset-load sets it to 1 only if negating the operand overflows, which happens for the most negative value; otherwise it sets it to 0.
- R10: When output-enable and load fall in the same cycle, the value driven is the sum from before that load.
- R11: With operands loaded in ticks 1 and 3 and output-enable in tick 5, the sum appears on the bus in tick 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | W | Operand taken from the value bus |
| ctlReset | input | 1 | With ctlLoad, starts a new sum |
| ctlLoad | input | 1 | Takes the operand in this cycle |
| ctlNeg | input | 1 | Negates the operand that is loaded |
| ctlOe | input | 1 | Requests a bus drive in the next cycle |
| busOut | output | W | Data contributed to the OR bus, zero when idle |
| busOvf | output | 1 | Overflow attribute contributed to the OR bus, zero when idle |

## Verification
Each load changes the internal sum at the clock edge where it is sampled. The sum can only be seen through a readout, and the data of a readout requested in cycle t is due on the bus in cycle t+1. A behavioural model in the bench advances at each rising edge from the same control inputs. Outputs are compared at the following falling edge, so every comparison sees exactly the registers that one edge has updated. Directed readouts check the value one cycle after each enable and check for zeros one cycle later.

// File: rtl/accum_pkg.sv
package accum_pkg;

  // Strobes from the line decoder to the datapath
  typedef struct packed {
    logic clear;       // start a new chain
    logic accumulate;  // operand is taken this cycle
    logic subtract;    // operand is negated
    logic capture;     // copy the sum into the output stage
  } accStrobe_t;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic       ctlReset,
  input  logic       ctlLoad,
  input  logic       ctlNeg,
  input  logic       ctlOe,
  output accStrobe_t strb
);

  // Reset and negate count only when load is raised
  always_comb begin
    strb.accumulate = ctlLoad;
    strb.clear      = ctlLoad & ctlReset;
    strb.subtract   = ctlLoad & ctlNeg;
    strb.capture    = ctlOe;
  end

endmodule

// File: rtl/accum_dp.sv
module accum_dp
  import accum_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  accStrobe_t   strb,
  input  logic [W-1:0] operand,
  output logic [W-1:0] accValue,
  output logic         accOvf
);

  localparam int MSB = W - 1;

  logic [W-1:0] baseVal;
  logic [W-1:0] sumVal;
  logic         stepOvf;
  logic         baseOvf;

  // The base is zero for a new chain, otherwise the running sum
  always_comb begin
    baseVal = strb.clear ? '0 : accValue;
    baseOvf = strb.clear ? 1'b0 : accOvf;
    if (strb.subtract) begin
      sumVal  = baseVal - operand;
      stepOvf = (baseVal[MSB] != operand[MSB]) && (sumVal[MSB] != baseVal[MSB]);
    end else begin
      sumVal  = baseVal + operand;
      stepOvf = (baseVal[MSB] == operand[MSB]) && (sumVal[MSB] != baseVal[MSB]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accValue <= '0;
      accOvf   <= 1'b0;
    end else if (strb.accumulate) begin
      accValue <= sumVal;
      accOvf   <= baseOvf | stepOvf;
    end
  end

  // R5
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accumulate |=> $stable(accValue) && $stable(accOvf));

  // R2
  clear_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear && !strb.subtract |=> accValue == $past(operand) && !accOvf);

  // R3
  add_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accumulate && !strb.clear && !strb.subtract
      |=> accValue == W'($past(accValue) + $past(operand)));

endmodule

// File: rtl/accum_out.sv
module accum_out
  import accum_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  accStrobe_t   strb,
  input  logic [W-1:0] accValue,
  input  logic         accOvf,
  output logic [W-1:0] busOut,
  output logic         busOvf
);

  logic [W-1:0] holdData;
  logic         holdOvf;
  logic         driveNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdOvf  <= 1'b0;
      driveNow <= 1'b0;
    end else begin
      driveNow <= strb.capture;
      if (strb.capture) begin
        holdData <= accValue;
        holdOvf  <= accOvf;
      end
    end
  end

  // The unit adds nothing to the OR bus while idle
  always_comb begin
    busOut = driveNow ? holdData : '0;
    busOvf = driveNow & holdOvf;
  end

endmodule

// File: rtl/accum_unit.sv
module accum_unit
  import accum_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] busIn,
  input  logic         ctlReset,
  input  logic         ctlLoad,
  input  logic         ctlNeg,
  input  logic         ctlOe,
  output logic [W-1:0] busOut,
  output logic         busOvf
);

  accStrobe_t   strb;
  logic [W-1:0] accValue;
  logic         accOvf;

  accum_ctrl u_ctrl (
    .ctlReset (ctlReset),
    .ctlLoad  (ctlLoad),
    .ctlNeg   (ctlNeg),
    .ctlOe    (ctlOe),
    .strb     (strb)
  );

  accum_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .operand  (busIn),
    .accValue (accValue),
    .accOvf   (accOvf)
  );

  accum_out #(.W(W)) u_out (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .accValue (accValue),
    .accOvf   (accOvf),
    .busOut   (busOut),
    .busOvf   (busOvf)
  );

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctlOe) |-> busOut == '0 && !busOvf);

  // R6
  drive_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlOe) |-> busOut == $past(accValue) && busOvf == $past(accOvf));

endmodule

// File: tb/accum_unit_tb.sv
module accum_unit_tb;

  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXS = (longint'(1) << (W - 1)) - 1;
  localparam longint MINS = -(longint'(1) << (W - 1));

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] busIn = '0;
  logic         ctlReset = 1'b0;
  logic         ctlLoad = 1'b0;
  logic         ctlNeg = 1'b0;
  logic         ctlOe = 1'b0;
  logic [W-1:0] busOut;
  logic         busOvf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  accum_unit #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .ctlReset(ctlReset),
    .ctlLoad(ctlLoad), .ctlNeg(ctlNeg), .ctlOe(ctlOe),
    .busOut(busOut), .busOvf(busOvf)
  );

  // Behavioural reference, advanced on each rising edge
  logic [W-1:0] mAcc = '0;
  bit           mOvf = 0;
  bit           mDrive = 0;
  logic [W-1:0] mData = '0;
  bit           mDataOvf = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = '0; mOvf = 0; mDrive = 0; mData = '0; mDataOvf = 0;
    end else begin
      mDrive = ctlOe;
      if (ctlOe) begin mData = mAcc; mDataOvf = mOvf; end
      if (ctlLoad) begin
        longint base, opnd, res;
        bit prior;
        base  = ctlReset ? 0 : longint'($signed(mAcc));
        prior = ctlReset ? 0 : mOvf;
        opnd  = longint'($signed(busIn));
        res   = ctlNeg ? base - opnd : base + opnd;
        mOvf  = prior || (res > MAXS) || (res < MINS);
        mAcc  = res[W-1:0];
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive one cycle, then compare against the model at the next falling edge
  task automatic tick(input logic r, input logic l, input logic n, input logic o,
                      input logic [W-1:0] b);
    ctlReset = r; ctlLoad = l; ctlNeg = n; ctlOe = o; busIn = b;
    @(negedge clk);
    if (mDrive) begin
      check("R6 model data", busOut, mData);
      check("R9 model ovf", W'(busOvf), W'(mDataOvf));
    end else begin
      check("R7 idle data", busOut, '0);
      check("R7 idle ovf", W'(busOvf), '0);
    end
  endtask

  task automatic readSum(input string tag, input logic [W-1:0] expVal, input bit expOvf);
    tick(0, 0, 0, 1, '0);
    check(tag, busOut, expVal);
    check({tag, " ovf"}, W'(busOvf), W'(expOvf));
    tick(0, 0, 0, 0, '0);
    check("R6 single cycle drive", busOut, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset data", busOut, '0);
    check("R1 reset ovf", W'(busOvf), '0);
    rstN = 1'b1;
    @(negedge clk);
    readSum("R1 sum after reset", '0, 0);

    // R11: operands in ticks 1 and 3, enable in tick 5, sum in tick 6
    tick(0, 0, 0, 0, '0);
    tick(1, 1, 0, 0, 32'd7);
    tick(0, 0, 0, 0, '0);
    tick(0, 1, 0, 0, 32'd1);
    tick(0, 0, 0, 0, '0);
    tick(0, 0, 0, 1, '0);
    check("R11 schedule sum", busOut, 32'd8);
    tick(0, 0, 0, 0, '0);

    // R2: replace, plain and negated
    tick(0, 1, 0, 0, 32'd100);
    tick(1, 1, 0, 0, 32'd5);
    readSum("R2 replace", 32'd5, 0);
    tick(1, 1, 1, 0, 32'd3);
    readSum("R2 replace negated", 32'hFFFF_FFFD, 0);

    // R3: chain of adds
    tick(1, 1, 0, 0, 32'd10);
    tick(0, 1, 0, 0, 32'd20);
    tick(0, 1, 0, 0, 32'd30);
    readSum("R3 add chain", 32'd60, 0);

    // R4: subtraction
    tick(1, 1, 0, 0, 32'd50);
    tick(0, 1, 1, 0, 32'd80);
    readSum("R4 subtract", 32'hFFFF_FFE2, 0);

    // R5: no load, noisy negate and bus
    tick(1, 1, 0, 0, 32'd42);
    tick(0, 0, 1, 0, 32'hDEAD_BEEF);
    tick(1, 0, 0, 0, 32'h1234_5678);
    tick(0, 0, 0, 0, 32'hFFFF_FFFF);
    readSum("R5 nop keeps sum", 32'd42, 0);

    // R8: wrap without signed overflow
    tick(1, 1, 0, 0, 32'hFFFF_FFFF);
    tick(0, 1, 0, 0, 32'd2);
    readSum("R8 wrap", 32'd1, 0);

    // R9: overflow, sticky, cleared by reset-load
    tick(1, 1, 0, 0, 32'h7FFF_FFFF);
    tick(0, 1, 0, 0, 32'd1);
    readSum("R9 overflow set", 32'h8000_0000, 1);
    tick(0, 1, 0, 0, 32'd0);
    readSum("R9 overflow sticky", 32'h8000_0000, 1);
    tick(1, 1, 0, 0, 32'd4);
    readSum("R9 overflow cleared", 32'd4, 0);
    tick(1, 1, 0, 0, 32'h8000_0000);
    tick(0, 1, 1, 0, 32'd1);
    readSum("R9 subtract overflow", 32'h7FFF_FFFF, 1);
    tick(1, 1, 1, 0, 32'h8000_0000);
    readSum("R9 negate most negative", 32'h8000_0000, 1);

    // R10: enable with load shows pre-load sum
    tick(1, 1, 0, 0, 32'd5);
    tick(0, 1, 0, 1, 32'd3);
    check("R10 pre-load value", busOut, 32'd5);
    tick(0, 0, 0, 0, '0);
    readSum("R10 later value", 32'd8, 0);

    // R6: back-to-back enables
    tick(0, 0, 0, 1, '0);
    check("R6 first enable", busOut, 32'd8);
    tick(0, 0, 0, 1, '0);
    check("R6 second enable", busOut, 32'd8);
    tick(0, 0, 0, 0, '0);
    check("R7 after enables", busOut, '0);

    // Mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      tick(c[0], c[1], c[2], c[3], $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule